// File: doc/BRIEF.md
# Region Prefetch Issue Scheduler

This block works next to a second-level cache and a multi-channel DRAM controller. When the cache reports a demand miss, the scheduler opens a region entry for the naturally aligned 4 KB region that holds the missed 64-byte block. It then works through the other blocks of that region and turns them into prefetch requests. Each request carries a block address and a hint that tells the cache where to place the fill in the recency order of its set. The default hint puts prefetched data in the position that is evicted first.

Before a block is sent out, the scheduler asks the cache whether the block is already resident, using a one-cycle tag probe. Blocks that are already present are dropped without being issued. A prefetch goes out only when the DRAM channel is idle and no demand traffic is waiting. When the scheduler chooses the next block, it looks at two things: how recently each region was touched, and whether the DRAM bank for each block is busy.

Top module: `rps_scheduler`

## Requirements
- R1: A region entry is created only in a cycle where `miss_valid` is high. The new entry's pending set holds every block of the region except the block that missed, so that block is never probed.
- R2: Up to N_ENT entries are held at once. A miss to a new region while all entries are live replaces the entry that was allocated or refreshed least recently.
- R3: A miss inside a region that is already tracked does not create a second entry. Instead it clears that block's pending bit and makes the region the youngest.
- R4: A block is probed with `probe_valid`/`probe_addr` for one cycle, and `probe_hit` is sampled in the cycle after. A hit clears the block's bit and no prefetch is issued for it. Every prefetch follows a probe of the same address in the cycle before.
- R5: `pf_valid` is never high while `demand_pending` or `miss_valid` is high. A block held back this way stays pending and is probed again later.
- R6: `pf_valid` is high only while `chan_idle` is high. A block held back by a busy channel stays pending.
- R7: Among entries with an eligible block, the youngest region is served first.
- R8: A block's bank is its block index modulo N_BANK, which is address bits [8:6] by default. Blocks whose bit in `bank_busy` is set are skipped. An entry whose pending blocks all sit in busy banks is not served.
- R9: Within the chosen entry, the eligible block with the lowest index is served first.
- R10: `pf_hint` encodes the insertion position: 0 = most recent, 1 = second most recent, 2 = second least recent, 3 = least recent. The default is 3.
- R11: An entry is released once its pending set is empty, and a released slot is reused before any live entry is replaced.
- R12: `pf_addr` and `probe_addr` equal the region base plus the block index times 64.
- R13: After reset, no entry is live and neither `probe_valid` nor `pf_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand miss reported by the cache this cycle |
| miss_addr | input | ADDR_W | Byte address of the demand miss |
| probe_hit | input | 1 | Tag-probe answer, valid in the cycle after `probe_valid` |
| bank_busy | input | N_BANK | Per-bank busy flags |
| chan_idle | input | 1 | DRAM channel has no traffic this cycle |
| demand_pending | input | 1 | A demand request is waiting for the channel |
| probe_valid | output | 1 | Tag probe request |
| probe_addr | output | ADDR_W | Block address being probed |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | ADDR_W | Block address to prefetch |
| pf_hint | output | 2 | Recency position for the filled block |

## Verification
The embedded properties are checked on every cycle. They cover five points: a prefetch never overlaps a demand miss or pending demand and never goes out on a busy channel; every prefetch repeats the address probed one cycle earlier; entries only appear on a miss, and no two live entries share a region; a live entry always has pending work; and the age ranks always form a permutation. Ordering can only be shown by the bench scenarios. These cover youngest-first service across regions, lowest-index order within a region, skipping of busy banks, replacement of the oldest entry, reuse of released slots, and retry of blocks that were held back. The bench drains whole regions and compares every probed address with a list it computes itself.

// File: rtl/rps_pkg.sv
package rps_pkg;
  timeunit 1ns; timeprecision 1ps;

  // Recency position a prefetched fill is inserted at.
  typedef enum logic [1:0] {
    INS_MRU  = 2'd0,
    INS_SMRU = 2'd1,
    INS_SLRU = 2'd2,
    INS_LRU  = 2'd3
  } ins_pos_e;

  // Probe / resolve sequencer states.
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_PROBE   = 2'd1,
    PS_RESOLVE = 2'd2
  } pstate_e;
endpackage

// File: rtl/rps_age_tracker.sv
// Keeps a recency rank per entry slot: 0 = youngest, N_ENT-1 = oldest.
module rps_age_tracker #(
  parameter int N_ENT = 4,
  parameter int ENT_W = 2
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch,
  input  logic [ENT_W-1:0]            touch_id,
  output logic [N_ENT-1:0][ENT_W-1:0] rank
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) rank[i] <= ENT_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (ENT_W'(i) == touch_id)         rank[i] <= '0;
        else if (rank[i] < rank[touch_id]) rank[i] <= rank[i] + ENT_W'(1);
      end
    end
  end

  // R2 / R7: the ranks stay a permutation, so exactly one slot is oldest.
  for (genvar r = 0; r < N_ENT; r++) begin : g_rank_chk
    logic [N_ENT-1:0] holds_r;
    always_comb
      for (int i = 0; i < N_ENT; i++) holds_r[i] = (rank[i] == ENT_W'(r));
    a_r2_rank_unique: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(holds_r));
  end
endmodule

// File: rtl/rps_block_pick.sv
// Lowest-index pending block whose bank is not busy.
module rps_block_pick #(
  parameter int NBLK   = 64,
  parameter int IDX_W  = 6,
  parameter int N_BANK = 8
)(
  input  logic [NBLK-1:0]   pend,
  input  logic [N_BANK-1:0] bank_busy,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (pend[i] && !bank_busy[i % N_BANK]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rps_entry_pick.sv
// Youngest entry among those with an eligible block.
module rps_entry_pick #(
  parameter int N_ENT = 4,
  parameter int ENT_W = 2
)(
  input  logic [N_ENT-1:0]            elig,
  input  logic [N_ENT-1:0][ENT_W-1:0] rank,
  output logic                        any,
  output logic [ENT_W-1:0]            sel
);
  timeunit 1ns; timeprecision 1ps;

  logic [ENT_W-1:0] best;
  always_comb begin
    any  = 1'b0;
    sel  = '0;
    best = '1;
    for (int i = 0; i < N_ENT; i++) begin
      if (elig[i] && (!any || rank[i] < best)) begin
        any  = 1'b1;
        sel  = ENT_W'(i);
        best = rank[i];
      end
    end
  end
endmodule

// File: rtl/rps_scheduler.sv
module rps_scheduler
  import rps_pkg::*;
#(
  parameter int       ADDR_W  = 32,
  parameter int       BLK_W   = 6,
  parameter int       REG_W   = 12,
  parameter int       N_ENT   = 4,
  parameter int       N_BANK  = 8,
  parameter ins_pos_e INS_POS = INS_LRU
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              probe_hit,
  input  logic [N_BANK-1:0] bank_busy,
  input  logic              chan_idle,
  input  logic              demand_pending,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [1:0]        pf_hint
);
  timeunit 1ns; timeprecision 1ps;

  localparam int IDX_W = REG_W - BLK_W;
  localparam int NBLK  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - REG_W;
  localparam int ENT_W = $clog2(N_ENT);

  function automatic logic [ADDR_W-1:0] blk_addr(input logic [TAG_W-1:0] t,
                                                 input logic [IDX_W-1:0] i);
    return {t, i, {BLK_W{1'b0}}};
  endfunction

  function automatic logic [NBLK-1:0] blk_mask(input logic [IDX_W-1:0] i);
    return NBLK'(1) << i;
  endfunction

  // Entry storage
  logic [N_ENT-1:0] ent_vld;
  logic [TAG_W-1:0] ent_tag  [N_ENT];
  logic [NBLK-1:0]  ent_pend [N_ENT];
  logic [N_ENT-1:0][ENT_W-1:0] rank;

  // Sequencer state
  pstate_e          st;
  logic [ENT_W-1:0] cap_ent;
  logic [IDX_W-1:0] cap_idx;

  // Miss decode
  logic [TAG_W-1:0] miss_tag;
  logic [IDX_W-1:0] miss_idx;
  logic             unused_lo;
  assign miss_tag  = miss_addr[ADDR_W-1:REG_W];
  assign miss_idx  = miss_addr[REG_W-1:BLK_W];
  assign unused_lo = ^miss_addr[BLK_W-1:0];

  logic [N_ENT-1:0] hit_vec;
  logic             hit_any, has_free;
  logic [ENT_W-1:0] hit_id, free_id, oldest_id, alloc_id;
  always_comb begin
    hit_any = 1'b0; hit_id = '0; has_free = 1'b0; free_id = '0; oldest_id = '0;
    for (int i = 0; i < N_ENT; i++) begin
      hit_vec[i] = ent_vld[i] && (ent_tag[i] == miss_tag);
      if (hit_vec[i]) begin hit_any = 1'b1; hit_id = ENT_W'(i); end
      if (rank[i] == ENT_W'(N_ENT - 1)) oldest_id = ENT_W'(i);
    end
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!ent_vld[i]) begin has_free = 1'b1; free_id = ENT_W'(i); end
  end
  assign alloc_id = has_free ? free_id : oldest_id;

  // Named events
  logic ev_refresh, ev_alloc, ev_evict, ev_go, ev_drop_hit, ev_issue;
  assign ev_refresh = miss_valid && hit_any;
  assign ev_alloc   = miss_valid && !hit_any;
  assign ev_evict   = ev_alloc && !has_free;

  // Candidate selection
  logic [N_ENT-1:0] blk_found, elig;
  logic [IDX_W-1:0] pick_idx [N_ENT];
  logic             pick_any;
  logic [ENT_W-1:0] pick_ent;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    rps_block_pick #(.NBLK(NBLK), .IDX_W(IDX_W), .N_BANK(N_BANK)) blk_pick_i (
      .pend(ent_pend[e]), .bank_busy(bank_busy),
      .found(blk_found[e]), .idx(pick_idx[e]));
    assign elig[e] = ent_vld[e] && blk_found[e];
  end

  rps_entry_pick #(.N_ENT(N_ENT), .ENT_W(ENT_W)) ent_pick_i (
    .elig(elig), .rank(rank), .any(pick_any), .sel(pick_ent));

  rps_age_tracker #(.N_ENT(N_ENT), .ENT_W(ENT_W)) age_i (
    .clk(clk), .rst_n(rst_n), .touch(miss_valid),
    .touch_id(hit_any ? hit_id : alloc_id), .rank(rank));

  logic traffic_clear;
  assign traffic_clear = chan_idle && !demand_pending && !miss_valid;
  assign ev_go       = (st == PS_IDLE) && pick_any && traffic_clear;
  assign ev_drop_hit = (st == PS_RESOLVE) && !miss_valid && probe_hit;
  assign ev_issue    = (st == PS_RESOLVE) && !probe_hit && traffic_clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PS_IDLE;
      cap_ent <= '0;
      cap_idx <= '0;
    end else begin
      case (st)
        PS_IDLE: if (ev_go) begin
          st      <= PS_PROBE;
          cap_ent <= pick_ent;
          cap_idx <= pick_idx[pick_ent];
        end
        PS_PROBE: st <= miss_valid ? PS_IDLE : PS_RESOLVE;
        default:  st <= PS_IDLE;
      endcase
    end
  end

  logic [NBLK-1:0] pend_left_miss, pend_left_res;
  assign pend_left_miss = ent_pend[hit_id]  & ~blk_mask(miss_idx);
  assign pend_left_res  = ent_pend[cap_ent] & ~blk_mask(cap_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        ent_tag[i]  <= '0;
        ent_pend[i] <= '0;
      end
    end else if (ev_refresh) begin
      ent_pend[hit_id] <= pend_left_miss;
      ent_vld[hit_id]  <= |pend_left_miss;
    end else if (ev_alloc) begin
      ent_vld[alloc_id]  <= 1'b1;
      ent_tag[alloc_id]  <= miss_tag;
      ent_pend[alloc_id] <= ~blk_mask(miss_idx);
    end else if (ev_drop_hit || ev_issue) begin
      ent_pend[cap_ent] <= pend_left_res;
      ent_vld[cap_ent]  <= |pend_left_res;
    end
  end

  assign probe_valid = (st == PS_PROBE);
  assign probe_addr  = blk_addr(ent_tag[cap_ent], cap_idx);
  assign pf_valid    = ev_issue;
  assign pf_addr     = blk_addr(ent_tag[cap_ent], cap_idx);
  assign pf_hint     = INS_POS;

  // Assertions
  a_r5_demand_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !demand_pending && !miss_valid);

  a_r6_channel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> chan_idle);

  a_r4_probe_before_issue: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(probe_valid) && ($past(probe_addr) == pf_addr));

  a_r1_alloc_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ent_vld) > $past($countones(ent_vld))) |-> $past(miss_valid));

  a_r3_no_dup_region: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> $countones(hit_vec) <= 1);

  a_r2_evict_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |-> &ent_vld);

  for (genvar e = 0; e < N_ENT; e++) begin : g_live_chk
    a_r11_live_has_work: assert property (@(posedge clk) disable iff (!rst_n)
      ent_vld[e] |-> |ent_pend[e]);
  end
endmodule

// File: tb/rps_scheduler_tb_top.sv
module rps_scheduler_tb_top;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic        probe_hit;
  logic [7:0]  bank_busy;
  logic        chan_idle;
  logic        demand_pending;
  logic        probe_valid;
  logic [31:0] probe_addr;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic [1:0]  pf_hint;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] got [0:511];
  logic [31:0] expv[0:511];
  int got_n;
  int exp_n;

  always #5 clk = ~clk;

  rps_scheduler dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .probe_hit(probe_hit), .bank_busy(bank_busy), .chan_idle(chan_idle),
    .demand_pending(demand_pending), .probe_valid(probe_valid),
    .probe_addr(probe_addr), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .pf_hint(pf_hint));

  function automatic logic [31:0] region(input int t);
    return 32'(t) << 12;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0; probe_hit = 1'b0;
    bank_busy = '0; chan_idle = 1'b1; demand_pending = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic miss(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a;
  endtask

  task automatic miss_end();
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic wait_probe(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk);
      if (probe_valid) seen = 1'b1;
    end
  endtask

  // kill: 0 none, 1 demand pending in resolve cycle, 2 channel busy
  task automatic serve(input bit hit, input int kill, input logic [31:0] ea,
                       input bit exp_issue, input string req);
    bit seen;
    wait_probe(seen);
    chk(seen, req, 32'(seen), 32'd1);
    if (!seen) return;
    chk(probe_addr == ea, req, probe_addr, ea);
    @(negedge clk);
    probe_hit = hit;
    if (kill == 1) demand_pending = 1'b1;
    if (kill == 2) chan_idle = 1'b0;
    #1;
    chk(pf_valid == exp_issue, req, 32'(pf_valid), 32'(exp_issue));
    if (exp_issue && pf_valid) begin
      chk(pf_addr == ea, {req, " R12"}, pf_addr, ea);
      chk(pf_hint == 2'd3, "R10 hint", 32'(pf_hint), 32'd3);
    end
    @(posedge clk); #1;
    probe_hit = 1'b0; demand_pending = 1'b0; chan_idle = 1'b1;
  endtask

  task automatic drain(input int maxn);
    bit seen;
    got_n = 0;
    while (got_n < maxn) begin
      wait_probe(seen);
      if (!seen) break;
      got[got_n] = probe_addr;
      got_n++;
      @(negedge clk);
      probe_hit = 1'b1;
      @(posedge clk); #1;
      probe_hit = 1'b0;
    end
  endtask

  task automatic cmp_lists(input string req);
    chk(got_n == exp_n, {req, " count"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got[i] == expv[i], req, got[i], expv[i]);
  endtask

  task automatic add_region(input int t, input int skip_a, input int skip_b);
    for (int i = 0; i < 64; i++)
      if (i != skip_a && i != skip_b) begin
        expv[exp_n] = region(t) + 32'(i * 64);
        exp_n++;
      end
  endtask

  initial begin
    #1_900_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit seen;
    do_reset();

    // R13: quiet after reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!probe_valid && !pf_valid, "R13 reset quiet",
          {30'd0, probe_valid, pf_valid}, 32'd0);
    end

    // R1 R9 R12 R10: sweep a whole region in index order, missed block skipped
    miss(region(32'h12) + 32'd64); miss_end();
    for (int i = 0; i < 64; i++)
      if (i != 1) serve(1'b0, 0, region(32'h12) + 32'(i * 64), 1'b1, "R1 R9 sweep");
    wait_probe(seen);
    chk(!seen, "R11 freed after drain", 32'(seen), 32'd0);

    // R4: probe hits are dropped and not re-probed
    do_reset();
    miss(region(32'h20)); miss_end();
    for (int i = 1; i < 4; i++)
      serve(1'b1, 0, region(32'h20) + 32'(i * 64), 1'b0, "R4 probe hit dropped");
    serve(1'b0, 0, region(32'h20) + 32'd256, 1'b1, "R4 next after hits");

    // R5: demand traffic blocks probes and issue, block retried
    do_reset();
    demand_pending = 1'b1;
    miss(region(32'h30) + 32'd320); miss_end();
    wait_probe(seen);
    chk(!seen, "R5 no probe while demand pending", 32'(seen), 32'd0);
    demand_pending = 1'b0;
    serve(1'b0, 1, region(32'h30), 1'b0, "R5 demand in resolve");
    serve(1'b0, 0, region(32'h30), 1'b1, "R5 retry");

    // R6: busy channel blocks probes and issue, block retried
    do_reset();
    chan_idle = 1'b0;
    miss(region(32'h31) + 32'd320); miss_end();
    wait_probe(seen);
    chk(!seen, "R6 no probe on busy channel", 32'(seen), 32'd0);
    chan_idle = 1'b1;
    serve(1'b0, 2, region(32'h31), 1'b0, "R6 busy in resolve");
    serve(1'b0, 0, region(32'h31), 1'b1, "R6 retry");

    // R8: busy banks skipped; all banks busy -> nothing
    do_reset();
    bank_busy = 8'hFE;
    miss(region(32'h40) + 32'(63 * 64)); miss_end();
    for (int i = 0; i < 3; i++)
      serve(1'b0, 0, region(32'h40) + 32'(i * 8 * 64), 1'b1, "R8 free bank only");
    bank_busy = 8'hFF;
    wait_probe(seen);
    chk(!seen, "R8 all banks busy", 32'(seen), 32'd0);
    bank_busy = 8'h00;
    serve(1'b0, 0, region(32'h40) + 32'd64, 1'b1, "R8 R9 banks freed");

    // R7 R3: youngest first, refresh on in-region miss
    do_reset();
    miss(region(32'h50)); miss(region(32'h51)); miss_end();
    serve(1'b0, 0, region(32'h51) + 32'd64, 1'b1, "R7 youngest region");
    miss(region(32'h50) + 32'(7 * 64)); miss_end();
    drain(400);
    exp_n = 0;
    add_region(32'h50, 0, 7);
    add_region(32'h51, 0, 1);
    cmp_lists("R3 R7 refresh order");

    // R2: oldest replaced when full
    do_reset();
    for (int r = 0; r < 5; r++) miss(region(32'h100 + r));
    miss_end();
    drain(400);
    exp_n = 0;
    for (int r = 4; r >= 1; r--) add_region(32'h100 + r, 0, 0);
    cmp_lists("R2 oldest evicted");

    // R11: freed slot reused before eviction
    do_reset();
    for (int r = 0; r < 4; r++) miss(region(32'h200 + r));
    miss_end();
    drain(63);
    chk(got_n == 63, "R11 first drain count", 32'(got_n), 32'd63);
    miss(region(32'h204)); miss_end();
    drain(400);
    exp_n = 0;
    add_region(32'h204, 0, 0);
    for (int r = 2; r >= 0; r--) add_region(32'h200 + r, 0, 0);
    cmp_lists("R11 slot reuse");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule